// File: doc/BRIEF.md
# Eight-Bit PWM Timer

This block is an 8-bit up-counter with a fixed 256-tick period. Its output is high from the start of each period until the count reaches a programmed compare value. The counter moves only on a count tick. The tick comes from one of four sources: the system clock, the system clock divided by four, a raw external clock edge, or an external clock edge passed through a synchronizer. Software places the configuration on plain input pins while the timer is stopped, then raises the run bit. Counting then begins at zero.

The waveform reaches the primary pin only when the port special-function select is set. Otherwise the pin carries a general-purpose value. A mirror control copies the waveform onto a second timer's pin. A sticky flag records every cycle in which the counter equals the active compare value. Compare writes made while the timer runs wait in a buffer and take effect at the next wrap to zero, so a period is never cut short.

The control is a three-state machine:
- STOP: the timer is halted and the count is cleared.
- HIGH: the count is below the active compare value.
- LOW: the count is at or above the active compare value.

The transitions are:
- STOP to HIGH, or STOP to LOW, when run is raised. HIGH is taken if the compare value is non-zero, LOW if it is zero.
- HIGH to LOW on the tick that brings the count up to the compare value.
- LOW to HIGH on the wrap from 0xFF to 0x00, if the newly loaded compare value is non-zero. Otherwise the state stays LOW.
- Any state to STOP when run is lowered.

Top module: `pwm_timer8`

## Requirements
- R1: While `run_en` is 0 the count is 0 and the waveform is low. On the first clock edge with `run_en` at 1 the count is still 0, and each later tick adds one.
- R2: While running with `pwm_mode` at 1, the waveform is high exactly while the count is below the active compare value. It goes low at the match. After count 0xFF, the next tick wraps the count to 0x00, and the output returns high if the compare value is non-zero.
- R3: A compare value of 0 gives an output that is low for the whole 256-tick period. A value of 255 gives 255 high ticks out of 256.
- R4: The `clk_sel` codes are 000 for every system clock, 001 for one tick in four system clocks, 010 for the raw external clock and 011 for the synchronized external clock. Codes 100 to 111 produce no ticks.
- R5: With code 010, a rising edge of `ext_clk` raises the count at the next clock edge. With code 011, it raises the count three clock edges later, and only once per edge.
- R6: With `pwm_mode` at 0 the waveform, and therefore both pins, stay low, while the counter keeps running.
- R7: `mirror_out` equals the waveform when `mirror_en` is 1, and is 0 otherwise.
- R8: `pin_out` carries the waveform when `port_sf` is 1, and `gpio_val` when `port_sf` is 0.
- R9: `match_flag` is set one edge after any running cycle in which the count equals the active compare value. It stays set until `match_clr` is applied in a cycle with no match.
- R10: A compare write while stopped takes effect at once. A write while running is buffered and becomes active on the wrap to 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run_en | input | 1 | Start (1) or stop and clear (0) |
| pwm_mode | input | 1 | Waveform enable |
| clk_sel | input | 3 | Count source code |
| cmp_wr | input | 1 | Compare write strobe |
| cmp_wdata | input | 8 | Compare write value |
| mirror_en | input | 1 | Copy the waveform to the second pin |
| port_sf | input | 1 | Pin carries the waveform (1) or `gpio_val` (0) |
| gpio_val | input | 1 | General-purpose pin value |
| ext_clk | input | 1 | External count clock |
| match_clr | input | 1 | Clear the sticky match flag |
| count_o | output | 8 | Current count |
| pin_out | output | 1 | Primary port pin |
| mirror_out | output | 1 | Second timer's pin |
| match_flag | output | 1 | Sticky compare-match flag |

## Verification
The count, the state and the match flag update on the clock edge after the inputs that cause them. The pins follow `port_sf`, `gpio_val`, `mirror_en` and `pwm_mode` within the same cycle. A raw external edge shows in the count one edge later, and a synchronized edge three edges later. The bench changes inputs just after a rising edge. A behavioural model advances on that edge, and the model and every output are compared at the following falling edge. Directed checks count whole edges from a known count (64 edges to the match, 256 to the wrap, three to a synchronized external tick) and sample only after the last of them.

// File: rtl/pt8_pkg.sv
package pt8_pkg;
    typedef enum logic [1:0] {
        ST_STOP = 2'd0,
        ST_HIGH = 2'd1,
        ST_LOW  = 2'd2
    } pt8_state_e;

    localparam logic [2:0] SRC_SYS     = 3'b000;
    localparam logic [2:0] SRC_SYS_DIV = 3'b001;
    localparam logic [2:0] SRC_EXT     = 3'b010;
    localparam logic [2:0] SRC_EXT_SYN = 3'b011;
endpackage

// File: rtl/pt8_tick_gen.sv
module pt8_tick_gen
    import pt8_pkg::*;
#(
    parameter int PRE_W  = 2,
    parameter int SYNC_N = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] sel,
    input  logic       ext_clk,
    output logic       tick
);
    localparam logic [PRE_W-1:0] PRE_LAST = {PRE_W{1'b1}};

    logic [PRE_W-1:0] pre_q;
    logic             raw_q;
    logic [SYNC_N:0]  sh_q;
    logic             raw_edge, syn_edge;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_q <= '0;
            raw_q <= 1'b0;
            sh_q  <= '0;
        end else begin
            pre_q <= pre_q + 1'b1;
            raw_q <= ext_clk;
            sh_q  <= {sh_q[SYNC_N-1:0], ext_clk};
        end
    end

    assign raw_edge = ext_clk & ~raw_q;
    assign syn_edge = sh_q[SYNC_N-1] & ~sh_q[SYNC_N];

    always_comb begin
        case (sel)
            SRC_SYS:     tick = 1'b1;
            SRC_SYS_DIV: tick = (pre_q == PRE_LAST);
            SRC_EXT:     tick = raw_edge;
            SRC_EXT_SYN: tick = syn_edge;
            default:     tick = 1'b0;
        endcase
    end

    p_off_codes_r4: assert property (@(posedge clk) disable iff (!rst_n)
        sel[2] |-> !tick);
    p_sync_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == SRC_EXT_SYN && tick && $stable(sel)) |=> !(tick && sel == SRC_EXT_SYN));
endmodule

// File: rtl/pt8_cmp_reg.sv
module pt8_cmp_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         stopped,
    input  logic         wrap,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] act_nxt,
    output logic [W-1:0] act
);
    logic [W-1:0] pend_q;

    always_comb begin
        if (stopped && wr)
            act_nxt = wdata;
        else if (wrap)
            act_nxt = pend_q;
        else
            act_nxt = act;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
            act    <= '0;
        end else begin
            if (wr)
                pend_q <= wdata;
            act <= act_nxt;
        end
    end

    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!stopped && !wrap) |=> $stable(act));
endmodule

// File: rtl/pwm_timer8.sv
module pwm_timer8
    import pt8_pkg::*;
#(
    parameter int CNT_W  = 8,
    parameter int PRE_W  = 2,
    parameter int SYNC_N = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_en,
    input  logic             pwm_mode,
    input  logic [2:0]       clk_sel,
    input  logic             cmp_wr,
    input  logic [CNT_W-1:0] cmp_wdata,
    input  logic             mirror_en,
    input  logic             port_sf,
    input  logic             gpio_val,
    input  logic             ext_clk,
    input  logic             match_clr,
    output logic [CNT_W-1:0] count_o,
    output logic             pin_out,
    output logic             mirror_out,
    output logic             match_flag
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    pt8_state_e       st_q, st_d;
    logic [CNT_W-1:0] cnt_q, cnt_inc, act, act_nxt;
    logic             tick, stopped, wrap, wave;

    pt8_tick_gen #(.PRE_W(PRE_W), .SYNC_N(SYNC_N)) u_tick (
        .clk(clk), .rst_n(rst_n), .sel(clk_sel), .ext_clk(ext_clk), .tick(tick)
    );

    pt8_cmp_reg #(.W(CNT_W)) u_cmp (
        .clk(clk), .rst_n(rst_n), .stopped(stopped), .wrap(wrap),
        .wr(cmp_wr), .wdata(cmp_wdata), .act_nxt(act_nxt), .act(act)
    );

    assign stopped = (st_q == ST_STOP);
    assign cnt_inc = cnt_q + 1'b1;
    assign wrap    = !stopped && tick && (cnt_q == CNT_MAX);

    always_comb begin
        st_d = st_q;
        if (!run_en) begin
            st_d = ST_STOP;
        end else begin
            unique case (st_q)
                ST_STOP: st_d = (act_nxt != '0) ? ST_HIGH : ST_LOW;
                ST_HIGH: if (tick && cnt_inc == act) st_d = ST_LOW;
                ST_LOW:  if (wrap) st_d = (act_nxt != '0) ? ST_HIGH : ST_LOW;
                default: st_d = ST_STOP;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q       <= ST_STOP;
            cnt_q      <= '0;
            match_flag <= 1'b0;
        end else begin
            st_q <= st_d;
            if (!run_en)
                cnt_q <= '0;
            else if (!stopped && tick)
                cnt_q <= cnt_inc;
            if (!stopped && cnt_q == act)
                match_flag <= 1'b1;
            else if (match_clr)
                match_flag <= 1'b0;
        end
    end

    always_comb begin
        wave       = pwm_mode && (st_q == ST_HIGH);
        pin_out    = port_sf ? wave : gpio_val;
        mirror_out = mirror_en & wave;
        count_o    = cnt_q;
    end

    p_stop_clears_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |=> (count_o == '0 && !wave));
    p_wave_vs_count_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !stopped |-> ((st_q == ST_HIGH) == (cnt_q < act)));
    p_mode_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !pwm_mode |-> !mirror_out);
    p_flag_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (match_flag && !match_clr) |=> match_flag);
endmodule

// File: tb/pwm_timer8_tb_top.sv
module pwm_timer8_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       run_en = 1'b0, pwm_mode = 1'b0, cmp_wr = 1'b0;
    logic [2:0] clk_sel = 3'b000;
    logic [7:0] cmp_wdata = 8'd0;
    logic       mirror_en = 1'b0, port_sf = 1'b0, gpio_val = 1'b0;
    logic       ext_clk = 1'b0, match_clr = 1'b0;
    logic [7:0] count_o;
    logic       pin_out, mirror_out, match_flag;

    int n_chk = 0;
    int n_bad = 0;
    int cyc_n = 0;

    always #2 clk = ~clk;

    pwm_timer8 dut_i (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .pwm_mode(pwm_mode),
        .clk_sel(clk_sel), .cmp_wr(cmp_wr), .cmp_wdata(cmp_wdata),
        .mirror_en(mirror_en), .port_sf(port_sf), .gpio_val(gpio_val),
        .ext_clk(ext_clk), .match_clr(match_clr), .count_o(count_o),
        .pin_out(pin_out), .mirror_out(mirror_out), .match_flag(match_flag)
    );

    // Behavioural reference model
    int m_cnt = 0, m_act = 0, m_pend = 0, m_pre = 0;
    bit m_run = 0, m_flag = 0;
    bit eh[3] = '{0, 0, 0};

    function automatic bit m_wave();
        return pwm_mode && m_run && (m_cnt < m_act);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_act = 0; m_pend = 0; m_pre = 0;
            m_run = 0; m_flag = 0; eh = '{0, 0, 0};
        end else begin
            bit tk;
            case (clk_sel)
                3'd0:    tk = 1;
                3'd1:    tk = (m_pre == 3);
                3'd2:    tk = ext_clk && !eh[0];
                3'd3:    tk = eh[1] && !eh[2];
                default: tk = 0;
            endcase
            if (m_run && m_cnt == m_act) m_flag = 1;
            else if (match_clr) m_flag = 0;
            if (!m_run && cmp_wr) m_act = cmp_wdata;
            else if (m_run && tk && m_cnt == 255) m_act = m_pend;
            if (cmp_wr) m_pend = cmp_wdata;
            if (!run_en) m_cnt = 0;
            else if (m_run && tk) m_cnt = (m_cnt + 1) % 256;
            m_run = run_en;
            m_pre = (m_pre + 1) % 4;
            eh[2] = eh[1]; eh[1] = eh[0]; eh[0] = ext_clk;
        end
    end

    task automatic chk(bit ok, string tag, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc_n);
        end
    endtask

    always @(negedge clk) begin
        cyc_n++;
        if (rst_n) begin
            bit w;
            w = m_wave();
            chk(count_o == 8'(m_cnt), "R4 count", count_o, m_cnt);
            chk(pin_out == (port_sf ? w : gpio_val), "R2 pin", pin_out, port_sf ? w : gpio_val);
            chk(mirror_out == (mirror_en && w), "R7 mirror", mirror_out, mirror_en && w);
            chk(match_flag == m_flag, "R9 flag", match_flag, m_flag);
        end
        if (cyc_n > 150000) begin
            chk(0, "watchdog", cyc_n, 150000);
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    task automatic cyc(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wr_cmp(int v);
        cmp_wr = 1'b1; cmp_wdata = 8'(v);
        cyc(1);
        cmp_wr = 1'b0;
    endtask

    task automatic restart(logic [2:0] sel, int v);
        run_en = 1'b0; cyc(1);
        clk_sel = sel; wr_cmp(v);
        run_en = 1'b1; cyc(1);
    endtask

    initial begin
        int c0, highs;
        cyc(4);
        rst_n = 1'b1;
        cyc(1);
        @(negedge clk);
        chk(count_o == 0 && pin_out == 0 && match_flag == 0, "R1 reset", count_o, 0);

        pwm_mode = 1; port_sf = 1;
        wr_cmp(64);
        run_en = 1; cyc(1);
        @(negedge clk);
        chk(count_o == 0, "R1 start at zero", count_o, 0);
        chk(pin_out == 1, "R2 high at zero", pin_out, 1);
        cyc(63); @(negedge clk);
        chk(pin_out == 1 && count_o == 63, "R2 high before match", pin_out, 1);
        cyc(1); @(negedge clk);
        chk(pin_out == 0, "R2 low at match", pin_out, 0);
        cyc(191); @(negedge clk);
        chk(count_o == 255 && pin_out == 0, "R2 low at top", count_o, 255);
        cyc(1); @(negedge clk);
        chk(count_o == 0 && pin_out == 1, "R2 wrap high", pin_out, 1);

        wr_cmp(200);
        cyc(99); @(negedge clk);
        chk(count_o == 100 && pin_out == 0, "R10 old compare kept", pin_out, 0);
        cyc(156); @(negedge clk);
        chk(count_o == 0, "R10 wrapped", count_o, 0);
        cyc(150); @(negedge clk);
        chk(pin_out == 1, "R10 new compare active", pin_out, 1);
        chk(match_flag == 1, "R9 flag set", match_flag, 1);
        match_clr = 1; cyc(1); match_clr = 0;
        @(negedge clk);
        chk(match_flag == 0, "R9 flag cleared", match_flag, 0);

        port_sf = 0; gpio_val = 1; @(negedge clk);
        chk(pin_out == 1, "R8 gpio one", pin_out, 1);
        gpio_val = 0; @(negedge clk);
        chk(pin_out == 0, "R8 gpio zero over high wave", pin_out, 0);
        port_sf = 1; mirror_en = 1; @(negedge clk);
        chk(mirror_out == 1 && pin_out == 1, "R7 mirror copy", mirror_out, 1);
        pwm_mode = 0; @(negedge clk);
        c0 = count_o;
        chk(pin_out == 0 && mirror_out == 0, "R6 held low", pin_out, 0);
        cyc(5); @(negedge clk);
        chk(count_o == 8'(c0 + 5), "R6 counter runs", count_o, c0 + 5);
        pwm_mode = 1;

        restart(3'd0, 0);
        highs = 0;
        for (int i = 0; i < 300; i++) begin
            @(negedge clk); if (pin_out) highs++; cyc(1);
        end
        chk(highs == 0, "R3 zero compare", highs, 0);
        restart(3'd0, 255);
        highs = 0;
        for (int i = 0; i < 256; i++) begin
            @(negedge clk); if (pin_out) highs++; cyc(1);
        end
        chk(highs == 255, "R3 full compare", highs, 255);

        restart(3'd1, 128);
        cyc(40); @(negedge clk);
        chk(count_o >= 9 && count_o <= 11, "R4 divide by four", count_o, 10);
        restart(3'd5, 128);
        cyc(50); @(negedge clk);
        chk(count_o == 0, "R4 idle code", count_o, 0);

        restart(3'd2, 128);
        for (int i = 0; i < 10; i++) begin
            ext_clk = 1; cyc(3); ext_clk = 0; cyc(3);
        end
        @(negedge clk);
        chk(count_o == 10, "R5 raw edges", count_o, 10);
        ext_clk = 1; cyc(1); @(negedge clk);
        chk(count_o == 11, "R5 raw latency", count_o, 11);
        ext_clk = 0;

        restart(3'd3, 128);
        cyc(4);
        c0 = count_o;
        ext_clk = 1; cyc(1); @(negedge clk);
        chk(count_o == c0, "R5 sync edge 1", count_o, c0);
        cyc(1); @(negedge clk);
        chk(count_o == c0, "R5 sync edge 2", count_o, c0);
        cyc(1); @(negedge clk);
        chk(count_o == c0 + 1, "R5 sync edge 3", count_o, c0 + 1);
        cyc(6); @(negedge clk);
        chk(count_o == c0 + 1, "R5 single count", count_o, c0 + 1);
        for (int i = 0; i < 8; i++) begin
            ext_clk = 0; cyc(4); ext_clk = 1; cyc(4);
        end

        run_en = 0; cyc(2); @(negedge clk);
        chk(count_o == 0 && pin_out == 0, "R1 stop clears", count_o, 0);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule